// File: doc/BRIEF.md
# SPI Transmit Drain Engine

This block empties a transmit byte queue over a full-duplex SPI link and files each returned byte into a receive byte queue. Whenever the master-inhibit input is low and the transmit queue offers a byte, the engine takes it, shifts it out on MOSI, and samples MISO on the same clock edges. The byte it assembles from MISO is then offered to the receive queue. It keeps doing this until the transmit queue runs dry or inhibit is raised again. Clearing inhibit therefore starts sending whatever was already waiting.

Each completed exchange produces single-cycle event pulses for the register unit, which ORs them into its sticky interrupt and status bits:

- transmit-empty
- receive-not-empty
- receive-full
- overrun

Register decoding, chip selects and the queues themselves live outside this block.

Both queue ports are valid/ready streams, with these back-pressure rules:

- On the transmit side, the engine raises `tx_ready` only while it is idle and not inhibited. It pops exactly one byte per handshake.
- On the receive side, `rx_valid` is offered for exactly one cycle and is never held. If `rx_ready` is low in that cycle, the engine does not stall: the byte is discarded and an overrun event is raised.

Top module: `spi_drain_engine`

## Requirements
- R1: After reset, `sclk` is low and `tx_ready`, `rx_valid` and all four event outputs are low.
- R2: While `inhibit` is high, no byte is taken from the transmit queue. Raising `inhibit` during an exchange lets that byte finish, and nothing further is taken.
- R3: With `inhibit` low, queued bytes are taken back to back. Successive pops are exactly 16*HALF_DIV+2 cycles apart until `tx_valid` falls.
- R4: The link runs in SPI mode 0 with the most significant bit first, as follows:
  - `sclk` idles low and has a period of 2*HALF_DIV clock cycles.
  - MOSI holds each bit while `sclk` is high.
  - MISO is sampled on the rising `sclk` edges.
  - The byte offered on `rx_data` equals the eight sampled MISO bits, first bit in bit 7.
- R5: The receive offer (`rx_valid`) appears 16*HALF_DIV+1 cycles after the cycle in which the transmit pop handshake is seen.
- R6: Every completed exchange pulses `ev_tx_empty` for one cycle. A delivered or overrun byte also pulses `ev_rx_not_empty` in that same cycle.
- R7: `ev_rx_full` pulses in the cycle of a successful push when `rx_level` equals DEPTH-1, which is when the push fills the queue.
- R8: If `rx_ready` is low when the byte completes, the byte is dropped and `ev_overrun` pulses. `ev_tx_empty` and `ev_rx_not_empty` still pulse, and the queue content is unchanged.
- R9: A `fifo_flush` pulse during an exchange lets the byte finish on the wire but suppresses its push. For that exchange, only `ev_tx_empty` pulses. The next exchange delivers normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inhibit | input | 1 | Master-inhibit flag; high blocks new exchanges |
| fifo_flush | input | 1 | Queue reset strobe; suppresses the in-flight push |
| tx_valid | input | 1 | Transmit queue has a byte |
| tx_ready | output | 1 | Engine takes the byte this cycle |
| tx_data | input | DATA_W | Transmit byte |
| rx_valid | output | 1 | Received byte offered (one cycle) |
| rx_ready | input | 1 | Receive queue not full |
| rx_data | output | DATA_W | Received byte |
| rx_level | input | LVL_W | Receive queue occupancy |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ev_tx_empty | output | 1 | Exchange-complete / transmit-empty event pulse |
| ev_rx_not_empty | output | 1 | Receive-not-empty event pulse |
| ev_rx_full | output | 1 | Receive-full event pulse |
| ev_overrun | output | 1 | Receive overrun event pulse |

## Verification
The bench timestamps every transmit handshake and every receive offer at the falling clock edge. It requires the receive offer to follow its pop by exactly 16*HALF_DIV+1 cycles, and successive pops to be 16*HALF_DIV+2 cycles apart. It also requires `sclk` rising edges to be 2*HALF_DIV cycles apart within a byte. The event pulses are combinational in the final cycle of the exchange, so they are counted in the same falling-edge sample as the receive offer. The inhibit, overrun and flush cases wait a generous number of cycles past the expected completion before comparing pop, push and event counts, so that a late or missing action is still observed.

// File: rtl/spi_drain_pkg.sv
package spi_drain_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DONE  = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/spi_edge_timer.sv
// Counts system clocks while an exchange runs; ticks every HALF_DIV cycles.
module spi_edge_timer #(
  parameter int HALF_DIV = 4,
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || tick)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_shift_unit.sv
// Mode-0 shifter: sample on rising sclk, shift on falling sclk, MSB first.
module spi_shift_unit #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              rise,
  input  logic              fall,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_byte
);
  logic [DATA_W-1:0] sh_q;
  logic              samp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      samp_q <= 1'b0;
    end else begin
      if (load)      sh_q <= load_data;
      else if (fall) sh_q <= {sh_q[DATA_W-2:0], samp_q};
      if (rise)      samp_q <= miso;
    end
  end

  assign mosi    = sh_q[DATA_W-1];
  assign rx_byte = sh_q;
endmodule

// File: rtl/spi_drain_engine.sv
module spi_drain_engine
  import spi_drain_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 256,
  parameter int HALF_DIV = 4,
  localparam int LVL_W   = $clog2(DEPTH + 1),
  localparam int BC_W    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inhibit,
  input  logic              fifo_flush,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  input  logic [LVL_W-1:0]  rx_level,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              ev_tx_empty,
  output logic              ev_rx_not_empty,
  output logic              ev_rx_full,
  output logic              ev_overrun
);
  xfer_state_e     st_q;
  logic            sclk_q;
  logic [BC_W-1:0] bit_q;
  logic            kill_q;
  logic            tick, rise, fall, last_bit, load, done, deliver;

  assign tx_ready = (st_q == ST_IDLE) && !inhibit;
  assign load     = tx_ready && tx_valid;
  assign rise     = tick && !sclk_q;
  assign fall     = tick && sclk_q;
  assign last_bit = fall && (bit_q == BC_W'(DATA_W - 1));
  assign done     = (st_q == ST_DONE);
  assign deliver  = done && !kill_q && !fifo_flush;

  spi_edge_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (st_q == ST_SHIFT),
    .tick (tick)
  );

  spi_shift_unit #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_data(tx_data),
    .rise     (rise),
    .fall     (fall),
    .miso     (miso),
    .mosi     (mosi),
    .rx_byte  (rx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sclk_q <= 1'b0;
      bit_q  <= '0;
      kill_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          sclk_q <= 1'b0;
          if (load) begin
            st_q   <= ST_SHIFT;
            bit_q  <= '0;
            kill_q <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (tick)       sclk_q <= ~sclk_q;
          if (fall)       bit_q  <= bit_q + 1'b1;
          if (last_bit)   st_q   <= ST_DONE;
          if (fifo_flush) kill_q <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign sclk            = sclk_q;
  assign rx_valid        = deliver;
  assign ev_tx_empty     = done;
  assign ev_rx_not_empty = deliver;
  assign ev_overrun      = deliver && !rx_ready;
  assign ev_rx_full      = deliver && rx_ready && (rx_level == LVL_W'(DEPTH - 1));
endmodule

// File: rtl/spi_drain_engine_chk.sv
module spi_drain_engine_chk
  import spi_drain_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        inhibit,
  input xfer_state_e st_q,
  input logic        tx_ready,
  input logic        rx_valid,
  input logic        rx_ready,
  input logic        sclk,
  input logic        mosi,
  input logic        ev_tx_empty,
  input logic        ev_rx_not_empty,
  input logic        ev_rx_full,
  input logic        ev_overrun
);
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_SHIFT) |-> !sclk); // R4
  AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi)); // R4
  AST_INHIBIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && st_q == ST_IDLE) |=> (st_q == ST_IDLE)); // R2
  AST_NO_POP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |-> !tx_ready); // R3
  AST_PUSH_EVENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |-> (ev_tx_empty && ev_rx_not_empty)); // R6
  AST_EVENT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_empty |=> !ev_tx_empty); // R6
  AST_FULL_ON_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_full |-> (rx_valid && rx_ready)); // R7
  AST_OVR_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overrun |-> (ev_tx_empty && !ev_rx_full)); // R8
endmodule

bind spi_drain_engine spi_drain_engine_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .inhibit        (inhibit),
  .st_q           (st_q),
  .tx_ready       (tx_ready),
  .rx_valid       (rx_valid),
  .rx_ready       (rx_ready),
  .sclk           (sclk),
  .mosi           (mosi),
  .ev_tx_empty    (ev_tx_empty),
  .ev_rx_not_empty(ev_rx_not_empty),
  .ev_rx_full     (ev_rx_full),
  .ev_overrun     (ev_overrun)
);

// File: tb/tb_spi_drain_engine.sv
`timescale 1ns/1ps
module tb_spi_drain_engine;
  localparam int H     = 2;
  localparam int DEPTH = 4;
  localparam int XFER  = 16*H + 1;
  localparam int GAP   = 16*H + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inhibit = 1'b1;
  logic fifo_flush = 1'b0;
  logic tx_valid, tx_ready, rx_valid, rx_ready, sclk, mosi, miso;
  logic [7:0] tx_data, rx_data;
  logic [2:0] rx_level;
  logic ev_tx_empty, ev_rx_not_empty, ev_rx_full, ev_overrun;

  always #5 clk = ~clk;

  spi_drain_engine #(.DATA_W(8), .DEPTH(DEPTH), .HALF_DIV(H)) dut (
    .clk(clk), .rst_n(rst_n), .inhibit(inhibit), .fifo_flush(fifo_flush),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_level(rx_level),
    .sclk(sclk), .mosi(mosi), .miso(miso),
    .ev_tx_empty(ev_tx_empty), .ev_rx_not_empty(ev_rx_not_empty),
    .ev_rx_full(ev_rx_full), .ev_overrun(ev_overrun)
  );

  function automatic logic [7:0] rep(input int n);
    return 8'hC3 ^ (8'(n) * 8'h25);
  endfunction

  // environment: transmit queue, receive queue, SPI slave
  logic [7:0] txq [16];
  logic [7:0] tx_head = 8'd0;
  logic [7:0] tx_tail = 8'd0;
  logic [7:0] rx_mem [DEPTH];
  logic [2:0] rx_cnt = 3'd0;
  logic [7:0] slv_sh = 8'd0, slv_got = 8'd0;
  logic [7:0] got_log [16];
  int         slv_n = 0, slv_bits = 0, got_n = 0, cyc = 0;
  logic       slv_sclk_q = 1'b0;

  assign tx_valid = (tx_head != tx_tail);
  assign tx_data  = txq[tx_head[3:0]];
  assign rx_ready = (rx_cnt < 3'(DEPTH));
  assign rx_level = rx_cnt;
  assign miso     = slv_sh[7];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tx_valid && tx_ready) tx_head <= tx_head + 8'd1;
    if (fifo_flush) rx_cnt <= 3'd0;
    else if (rx_valid && rx_ready) begin
      rx_mem[rx_cnt[1:0]] <= rx_data;
      rx_cnt <= rx_cnt + 3'd1;
    end
    if (tx_valid && tx_ready) begin
      slv_sh   <= rep(slv_n);
      slv_n    <= slv_n + 1;
      slv_bits <= 0;
    end else begin
      if (sclk && !slv_sclk_q) begin
        slv_got <= {slv_got[6:0], mosi};
        if (slv_bits == 7) begin
          got_log[got_n[3:0]] <= {slv_got[6:0], mosi};
          got_n <= got_n + 1;
        end
        slv_bits <= slv_bits + 1;
      end
      if (!sclk && slv_sclk_q) slv_sh <= {slv_sh[6:0], 1'b0};
    end
    slv_sclk_q <= sclk;
  end

  // monitor, sampled away from the active edge
  int pops = 0, pushes = 0, n_te = 0, n_rne = 0, n_full = 0, n_ovr = 0, rises = 0;
  int last_pop = 0, pop_gap = 0, push_delta = 0, last_rise = 0, rise_gap = 0;
  logic sclk_prev = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (tx_valid && tx_ready) begin
      if (pops > 0) pop_gap = cyc - last_pop;
      last_pop = cyc;
      pops++;
    end
    if (rx_valid && rx_ready) begin push_delta = cyc - last_pop; pushes++; end
    if (ev_tx_empty) n_te++;
    if (ev_rx_not_empty) n_rne++;
    if (ev_rx_full) n_full++;
    if (ev_overrun) n_ovr++;
    if (sclk && !sclk_prev) begin
      if (rises > 0) rise_gap = cyc - last_rise;
      last_rise = cyc;
      rises++;
    end
    sclk_prev = sclk;
  end

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    txq[tx_tail[3:0]] = b;
    tx_tail = tx_tail + 8'd1;
  endtask

  task automatic wait_te(input int tgt);
    for (int i = 0; i < 3000 && n_te < tgt; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_flush();
    @(negedge clk) fifo_flush = 1'b1;
    @(negedge clk) fifo_flush = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(sclk == 1'b0, "R1 sclk low", sclk, 0);
    chk(tx_ready == 1'b0 && rx_valid == 1'b0, "R1 handshakes low", {tx_ready, rx_valid}, 0);
    chk({ev_tx_empty, ev_rx_not_empty, ev_rx_full, ev_overrun} == 4'b0, "R1 events low",
        {ev_tx_empty, ev_rx_not_empty, ev_rx_full, ev_overrun}, 0);
  endtask

  task automatic t_inhibit();
    send(8'h5A); send(8'h96);
    repeat (60) @(negedge clk);
    chk(pops == 0, "R2 no pop while inhibited", pops, 0);
    chk(rises == 0, "R2 no sclk while inhibited", rises, 0);
  endtask

  task automatic t_release();
    @(negedge clk) inhibit = 1'b0;
    wait_te(2);
    inhibit = 1'b1;
    chk(got_log[0] == 8'h5A, "R4 mosi byte 0 msb first", got_log[0], 8'h5A);
    chk(got_log[1] == 8'h96, "R4 mosi byte 1 msb first", got_log[1], 8'h96);
    chk(rx_mem[0] == rep(0), "R4 miso byte 0", rx_mem[0], rep(0));
    chk(rx_mem[1] == rep(1), "R4 miso byte 1", rx_mem[1], rep(1));
    chk(rise_gap == 2*H, "R4 sclk period", rise_gap, 2*H);
    chk(push_delta == XFER, "R5 pop to push latency", push_delta, XFER);
    chk(pop_gap == GAP, "R3 back-to-back pops", pop_gap, GAP);
    chk(pops == 2 && !tx_valid, "R3 drained until empty", pops, 2);
    chk(n_te == 2 && n_rne == 2, "R6 events per exchange", {n_te, n_rne}, {32'd2, 32'd2});
  endtask

  task automatic t_stop_mid();
    send(8'h11); send(8'h22);
    @(negedge clk) inhibit = 1'b0;
    for (int i = 0; i < 100 && pops < 3; i++) @(negedge clk);
    inhibit = 1'b1;
    repeat (120) @(negedge clk);
    chk(n_te == 3 && pops == 3, "R2 current byte finishes, no more popped", pops, 3);
    chk(tx_valid == 1'b1, "R2 remaining byte stays queued", tx_valid, 1);
  endtask

  task automatic t_full();
    @(negedge clk) inhibit = 1'b0;
    wait_te(4);
    chk(n_full == 1, "R7 full event on filling push", n_full, 1);
    chk(rx_cnt == 3'd4, "R7 queue at depth", rx_cnt, 4);
    chk(rx_mem[3] == rep(3), "R7 last byte stored", rx_mem[3], rep(3));
  endtask

  task automatic t_overrun();
    send(8'h7E);
    wait_te(5);
    chk(n_ovr == 1, "R8 overrun event", n_ovr, 1);
    chk(pushes == 4 && rx_cnt == 3'd4, "R8 byte dropped", pushes, 4);
    chk(rx_mem[3] == rep(3), "R8 stored data unchanged", rx_mem[3], rep(3));
    chk(n_te == 5 && n_rne == 5, "R8 exchange still completes", {n_te, n_rne}, {32'd5, 32'd5});
    chk(n_full == 1, "R8 no full event on overrun", n_full, 1);
  endtask

  task automatic t_flush_mid();
    int r0;
    pulse_flush();
    @(negedge clk);
    chk(rx_cnt == 3'd0, "R9 queue emptied", rx_cnt, 0);
    r0 = rises;
    send(8'hE7);
    for (int i = 0; i < 200 && rises < r0 + 3; i++) @(negedge clk);
    pulse_flush();
    wait_te(6);
    chk(got_log[5] == 8'hE7, "R9 byte finishes on wire", got_log[5], 8'hE7);
    chk(pushes == 4 && rx_cnt == 3'd0, "R9 push suppressed", pushes, 4);
    chk(n_rne == 5 && n_ovr == 1, "R9 only tx-empty event", {n_rne, n_ovr}, {32'd5, 32'd1});
    send(8'h3D);
    wait_te(7);
    chk(pushes == 5 && rx_mem[0] == rep(6), "R9 next exchange delivers", rx_mem[0], rep(6));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_inhibit();
    t_release();
    t_stop_mid();
    t_full();
    t_overrun();
    t_flush_mid();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R3 drain hung actual=%0d expected=done", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule